// File: doc/BRIEF.md
# One-Time-Programmable Byte Store

This block is a synthesizable behavioural model of a byte-wide one-time-programmable memory and the logic that decodes its control pins. Every cell powers up holding all ones. A programming pass can only pull bits to zero, and no later write can return a cleared bit to one. The data bus is split into `din`, `dout` and `dout_en`, so that the chip-level tri-state driver sits outside the block. Two level flags stand in for the electrical conditions of the real part. `vprog_hi` means the high programming supply is present. `id_hv` means the identification voltage is present on address line 9.

The block decodes the active-low chip enable, output enable and program strobe, together with the two flags, into one of these modes: standby, output off, read, program, program inhibit and program verify. A further mode reads out two fixed identification bytes.

The program strobe is sampled on `clk`. One byte is committed on the first clock edge that sees the strobe low after it was seen high. All reads are combinational from the address. The stream style of the wider design does not apply here: the block is a pin-level slave with no flow control and no back-pressure. `rst_n` clears only the strobe history. It never touches the stored array.

Top module: `otp_byte_store`

## Requirements
- R1: After power-up, every address reads as 0xFF until that address is programmed.
- R2: With `ce_n`=0, `oe_n`=0 and `vprog_hi`=0 and `id_hv`=0, `dout_en`=1 and `dout` shows the byte at `addr`, whatever the level of `pgm_n`.
- R3: When `dout_en`=0, `dout` reads 0x00. In particular, `ce_n`=1 (standby) or `oe_n`=1 (output off) always gives `dout_en`=0.
- R4: With `ce_n`=0, `oe_n`=1 and `vprog_hi`=1, the first clock edge that samples `pgm_n` low after sampling it high stores `din` at `addr`. A read one cycle later shows the result.
- R5: A store sets the cell to (old AND `din`). Bits already at 0 stay 0, even when `din` carries 1s in those positions.
- R6: No store happens on a strobe falling edge that occurs while `ce_n`=1, `oe_n`=0 or `vprog_hi`=0.
- R7: Each high-to-low strobe transition stores at most one byte. Changes to `din` while `pgm_n` stays low are not stored.
- R8: With `vprog_hi`=1, `ce_n`=0 and `oe_n`=0, the stored byte is driven when `pgm_n`=1 (verify). When `pgm_n`=0 the bus is not driven.
- R9: With `id_hv`=1, `vprog_hi`=0, `ce_n`=0 and `oe_n`=0, `dout` is 0x97 when `addr[0]`=0 and 0xD6 when `addr[0]`=1, regardless of the array contents.
- R10: `dout_en` = !`ce_n` & !`oe_n` & (!`vprog_hi` | `pgm_n`). The bus is driven only in read, verify and identification modes.
- R11: If `pgm_n` is low when reset is released, nothing is stored until `pgm_n` has been sampled high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the program strobe |
| rst_n | input | 1 | Active-low reset of the strobe history |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Read data, 0x00 when not driven |
| dout_en | output | 1 | High when the bus should be driven |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program strobe |
| vprog_hi | input | 1 | Programming supply present |
| id_hv | input | 1 | Identification voltage present on address line 9 |

## Verification
The embedded properties check several rules on every clock:
- the bus is never driven in standby or output-off;
- a store happens only under the program-mode pin pattern;
- no two stores come back to back;
- a stored cell never gains a 1 bit;
- identification mode returns only one of the two fixed bytes.

Other behaviour can only be shown by the directed scenarios, because it depends on what was written earlier:
- the exact byte read back after AND-accumulation;
- the rejection of strobes under each inhibit condition;
- the single store across a long strobe with `din` changing;
- the blocked store after a reset released with the strobe low;
- the identification bytes overriding programmed data.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    M_STANDBY   = 3'd0,
    M_OUT_OFF   = 3'd1,
    M_READ      = 3'd2,
    M_PROGRAM   = 3'd3,
    M_INHIBIT   = 3'd4,
    M_VERIFY    = 3'd5,
    M_IDENT     = 3'd6,
    M_CONFLICT  = 3'd7
  } otp_mode_e;

  localparam logic [7:0] ID_MAKER = 8'h97;
  localparam logic [7:0] ID_PART  = 8'hD6;

  function automatic logic mode_drives(input otp_mode_e m);
    return (m == M_READ) || (m == M_VERIFY) || (m == M_IDENT);
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      pgm_n,
  input  logic      vprog_hi,
  input  logic      id_hv,
  output otp_mode_e mode,
  output logic      drive
);

  always_comb begin
    if (ce_n) begin
      mode = M_STANDBY;
    end else if (oe_n) begin
      // output enable high: programming family or plain output-off
      if (!vprog_hi)   mode = M_OUT_OFF;
      else if (!pgm_n) mode = M_PROGRAM;
      else             mode = M_INHIBIT;
    end else begin
      if (vprog_hi)    mode = pgm_n ? M_VERIFY : M_CONFLICT;
      else if (id_hv)  mode = M_IDENT;
      else             mode = M_READ;
    end
  end

  assign drive = mode_drives(mode);

endmodule

// File: rtl/otp_strobe_edge.sv
module otp_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_n,
  input  logic prog_mode,
  output logic wr_en
);

  // History resets low, so a strobe held low through reset is not an edge.
  logic seen_high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_high_q <= 1'b0;
    else        seen_high_q <= pgm_n;
  end

  assign wr_en = rst_n && seen_high_q && !pgm_n && prog_mode;

  a_r7_one_store_per_edge: assert property (
    @(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en);

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // Power-up state of an unprogrammed part: every bit set.
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= cells[addr] & wdata;
  end

  assign rdata = cells[addr];

  a_r5_never_sets_bit: assert property (
    @(posedge clk) disable iff (!rst_n)
    we |=> ((cells[$past(addr)] & ~$past(rdata)) == '0));

endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
  import otp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vprog_hi,
  input  logic              id_hv
);

  otp_mode_e  mode;
  logic       drive;
  logic       wr_en;
  logic [7:0] cell_q;

  otp_mode_decode u_decode (
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .pgm_n    (pgm_n),
    .vprog_hi (vprog_hi),
    .id_hv    (id_hv),
    .mode     (mode),
    .drive    (drive)
  );

  otp_strobe_edge u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .pgm_n     (pgm_n),
    .prog_mode (mode == M_PROGRAM),
    .wr_en     (wr_en)
  );

  otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_cells (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .addr  (addr),
    .wdata (din),
    .rdata (cell_q)
  );

  always_comb begin
    unique case (mode)
      M_READ, M_VERIFY: dout = cell_q;
      M_IDENT:          dout = addr[0] ? ID_PART : ID_MAKER;
      default:          dout = 8'h00;
    endcase
  end

  assign dout_en = drive;

  a_r3_quiet_when_disabled: assert property (
    @(posedge clk) disable iff (!rst_n) (ce_n || oe_n) |-> !dout_en);

  a_r10_drive_needs_enables: assert property (
    @(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && !oe_n && (!vprog_hi || pgm_n)));

  a_r4_store_needs_program_pins: assert property (
    @(posedge clk) disable iff (!rst_n)
    wr_en |-> (!ce_n && oe_n && vprog_hi && !pgm_n));

  a_r9_ident_bytes_only: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vprog_hi && id_hv) |-> (dout == ID_MAKER || dout == ID_PART));

endmodule

// File: tb/test_otp_byte_store.sv
module test_otp_byte_store;

  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'hFF;
  logic [7:0]    dout;
  logic          dout_en;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vprog_hi = 1'b0, id_hv = 1'b0;

  logic [7:0] model [N];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otp_byte_store #(.ADDR_W(AW)) i_otp_byte_store (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vprog_hi(vprog_hi), .id_hv(id_hv));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0; pgm_n = 1; vprog_hi = 0; id_hv = 0;
    #2;
    chk({req, " dout_en"}, {7'd0, dout_en}, 8'h01);
    chk({req, " data"}, dout, model[a]);
  endtask

  // strobe under given controls; model updates only when a store is legal
  task automatic strobe(input logic [AW-1:0] a, input logic [7:0] d,
                        input logic ce, input logic oe, input logic vp);
    @(negedge clk);
    addr = a; din = d; ce_n = ce; oe_n = oe; vprog_hi = vp; id_hv = 0; pgm_n = 1;
    @(negedge clk);
    pgm_n = 0;
    @(negedge clk);
    pgm_n = 1;
    if (!ce && oe && vp) model[a] = model[a] & d;
  endtask

  task automatic t_power_up;
    @(negedge clk);
    ce_n = 1; #2;
    chk("R3 standby en", {7'd0, dout_en}, 8'h00);
    chk("R3 standby data", dout, 8'h00);
    for (int i = 0; i < N; i++) read_at(i[AW-1:0], "R1 erased");
  endtask

  task automatic t_program;
    strobe(6'd5, 8'hA5, 0, 1, 1);
    strobe(6'd63, 8'h00, 0, 1, 1);
    strobe(6'd17, 8'h7E, 0, 1, 1);
    read_at(6'd5, "R4 store");
    read_at(6'd63, "R4 store");
    read_at(6'd17, "R2 read");
    read_at(6'd18, "R2 neighbour");
  endtask

  task automatic t_clear_only;
    strobe(6'd9, 8'hF0, 0, 1, 1);
    strobe(6'd9, 8'h3C, 0, 1, 1);
    read_at(6'd9, "R5 and-accumulate");
    strobe(6'd9, 8'hFF, 0, 1, 1);
    read_at(6'd9, "R5 ones ignored");
  endtask

  task automatic t_inhibit;
    strobe(6'd20, 8'h00, 1, 1, 1);
    read_at(6'd20, "R6 ce high");
    strobe(6'd21, 8'h00, 0, 1, 0);
    read_at(6'd21, "R6 no supply");
    strobe(6'd22, 8'h00, 0, 0, 1);
    read_at(6'd22, "R6 oe low");
  endtask

  task automatic t_single_edge;
    @(negedge clk);
    addr = 6'd30; din = 8'hFF; ce_n = 0; oe_n = 1; vprog_hi = 1; pgm_n = 1;
    @(negedge clk); pgm_n = 0; din = 8'hEF;
    @(negedge clk); din = 8'hFE;
    @(negedge clk); din = 8'h00;
    @(negedge clk); pgm_n = 1;
    model[30] = 8'hEF;
    read_at(6'd30, "R7 single store");
  endtask

  task automatic t_verify;
    @(negedge clk);
    addr = 6'd5; ce_n = 0; oe_n = 0; vprog_hi = 1; pgm_n = 1; id_hv = 0;
    #2;
    chk("R8 verify en", {7'd0, dout_en}, 8'h01);
    chk("R8 verify data", dout, 8'hA5);
    pgm_n = 0; #2;
    chk("R8 strobe low en", {7'd0, dout_en}, 8'h00);
    chk("R3 strobe low data", dout, 8'h00);
    @(negedge clk); pgm_n = 1;
  endtask

  task automatic t_ident;
    strobe(6'd0, 8'h12, 0, 1, 1);
    strobe(6'd1, 8'h34, 0, 1, 1);
    @(negedge clk);
    ce_n = 0; oe_n = 0; vprog_hi = 0; pgm_n = 1; id_hv = 1; addr = 6'd0;
    #2;
    chk("R9 maker", dout, 8'h97);
    chk("R9 maker en", {7'd0, dout_en}, 8'h01);
    addr = 6'd1; #2;
    chk("R9 part", dout, 8'hD6);
    @(negedge clk); id_hv = 0;
    read_at(6'd0, "R9 array kept");
  endtask

  task automatic t_drive_table;
    for (int v = 0; v < 32; v++) begin
      logic exp_en;
      @(negedge clk);
      addr = 6'd5;
      {ce_n, oe_n, pgm_n, vprog_hi, id_hv} = v[4:0];
      #2;
      exp_en = !ce_n && !oe_n && (!vprog_hi || pgm_n);
      chk("R10 drive table", {7'd0, dout_en}, {7'd0, exp_en});
      if (!exp_en) chk("R3 idle data", dout, 8'h00);
    end
    @(negedge clk);
    ce_n = 1; oe_n = 1; pgm_n = 1; vprog_hi = 0; id_hv = 0;
  endtask

  task automatic t_reset_low_strobe;
    @(negedge clk);
    addr = 6'd40; din = 8'h0F; ce_n = 0; oe_n = 1; vprog_hi = 1; pgm_n = 0;
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    pgm_n = 1;
    read_at(6'd40, "R11 no store after reset");
    strobe(6'd40, 8'h0F, 0, 1, 1);
    read_at(6'd40, "R11 store after rearm");
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_power_up();
    t_program();
    t_clear_only();
    t_inhibit();
    t_single_edge();
    t_verify();
    t_ident();
    t_drive_table();
    t_reset_low_strobe();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule